// File: doc/BRIEF.md
# Beacon event timer unit

This block keeps a free-running microsecond timestamp counter and derives four periodic beacon-related event pulses from it. The counter advances once per clock cycle in which the microsecond tick input is high. Software loads four next-event compare registers and one control register through a single-cycle register write port. Two compare registers count in time units (1 TU = 2^TU_LOG2 microseconds, 1024 by default): next beacon and end of the announcement window. The other two count in eighths of a TU: DMA beacon alert and software beacon alert. Each register is matched against the matching slice of the counter.

While the unit is armed, an event pulses for one cycle when its counter slice first equals its compare value. That compare value then steps forward by one beacon period, which is scaled by 8 for the eighth-TU registers. The unit is armed when the enable bit is set, the period is nonzero and the last value written to the next-beacon register was nonzero. A counter-clear bit in the control register clears the counter on every write that carries it. Each such write also flips an internal flag that survives block reset. While that flag is high, a block reset clears the counter too, so software writes the bit an even number of times. The intended programming order is: compare registers first, then control. The announcement-window compare is at least one TU past the next beacon. Each alert is programmed as (next beacon minus its response time) times 8.

Top module: `bcn_event_timer`

## Requirements
- R1: The counter `tsf_us` is zero at power-up. It increases by one at each rising clock edge where `tick` is high and holds its value at every other edge, except as R2 and R3 state.
- R2: A write to address 4 (control) with bit PER_W+1 (the clear bit) set makes `tsf_us` read zero in the next cycle, whatever the enable bit. Control bits [PER_W-1:0] hold the beacon period in TU and bit PER_W is the enable.
- R3: While `rst` is high, the counter holds its value if an even number of clear-bit writes have occurred since power-up, and is forced to zero if an odd number have. The flag behind this is not cleared by `rst`. `rst` clears all compare registers, the period, the enable and all event outputs.
- R4: Address 0 (next beacon) and address 3 (announcement-window end) take a TU value, which is compared with `tsf_us >> TU_LOG2`. The matching event (`ev_tbtt` or `ev_win_end`) is high for exactly one cycle: the cycle after the first cycle in which the slice equals the register.
- R5: Address 1 (DMA alert) and address 2 (software alert) take an eighth-TU value, which is compared with `tsf_us >> (TU_LOG2-3)`. `ev_dma_alert` and `ev_sw_alert` pulse with the same timing as in R4.
- R6: After each event, its compare value advances by the period for the TU registers and by 8 times the period for the eighth-TU registers. With `tick` high every cycle, each channel therefore repeats every period × 2^TU_LOG2 cycles.
- R7: No event is raised while the enable bit is clear. A match that the counter passes while disabled does not fire when the enable is later set.
- R8: When the last value written to address 0 is zero, none of the four events fires. Writing a nonzero value there restores them.
- R9: A beacon period of zero suppresses all four events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | One-cycle microsecond tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..4) |
| wr_data | input | WD_W | Register write data |
| tsf_us | output | TSF_W | Microsecond timestamp counter |
| ev_tbtt | output | 1 | Next-beacon event pulse |
| ev_dma_alert | output | 1 | DMA beacon alert pulse |
| ev_sw_alert | output | 1 | Software beacon alert pulse |
| ev_win_end | output | 1 | Announcement-window end pulse |

## Verification
The bench builds the unit with TSF_W=16, TU_LOG2=4 and PER_W=8. With these values a TU is 16 ticks and an eighth of a TU is 2 ticks, so several repetitions of every channel fit into a couple of hundred cycles. The bench sweeps every combination of next-beacon values 1 to 4 and periods 1 to 3. It predicts the counter reading at each pulse as compare × slice weight + 1, plus 16 × period per repetition. The small counter also lets the bench cover, in short runs, both parities of the clear flag across block reset and the passed-while-disabled case.

// File: rtl/bcn_pkg.sv
package bcn_pkg;

  typedef enum logic [2:0] {
    ADDR_NEXT_BCN  = 3'd0,
    ADDR_DMA_ALERT = 3'd1,
    ADDR_SW_ALERT  = 3'd2,
    ADDR_WIN_END   = 3'd3,
    ADDR_CTRL      = 3'd4
  } bcn_addr_e;

  localparam int NUM_SLOTS = 4;

  // slots 1 and 2 count in eighths of a time unit
  function automatic bit slot_is_fine(input int idx);
    return (idx == 1) || (idx == 2);
  endfunction

endpackage

// File: rtl/bcn_tsf_counter.sv
module bcn_tsf_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr_req,
  output logic [W-1:0] tsf
);

  // power-up state; neither register is cleared by rst itself
  logic         tog_q = 1'b0;
  logic [W-1:0] cnt_q = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (tog_q) cnt_q <= '0;
    end else if (clr_req) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else if (tick) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign tsf = cnt_q;

endmodule

// File: rtl/bcn_cmp_slot.sv
module bcn_cmp_slot #(
  parameter int CW    = 22,
  parameter int PER_W = 16,
  parameter int PS    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    field,
  input  logic             load,
  input  logic [CW-1:0]    load_val,
  input  logic [PER_W-1:0] period,
  input  logic             arm,
  output logic             fire
);

  logic [CW-1:0] cmp_q;
  logic          hit;

  assign hit = arm && (field == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= hit;
      if (load)
        cmp_q <= load_val;
      else if (hit)
        cmp_q <= cmp_q + (CW'(period) << PS);
    end
  end

endmodule

// File: rtl/bcn_event_timer.sv
module bcn_event_timer
  import bcn_pkg::*;
#(
  parameter int TSF_W   = 32,
  parameter int TU_LOG2 = 10,
  parameter int PER_W   = 16,
  localparam int SUB_LOG2 = TU_LOG2 - 3,
  localparam int SUB_CW   = TSF_W - SUB_LOG2,
  localparam int WD_W     = (SUB_CW > PER_W + 2) ? SUB_CW : PER_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WD_W-1:0]  wr_data,
  output logic [TSF_W-1:0] tsf_us,
  output logic             ev_tbtt,
  output logic             ev_dma_alert,
  output logic             ev_sw_alert,
  output logic             ev_win_end
);

  localparam int EN_BIT  = PER_W;
  localparam int CLR_BIT = PER_W + 1;
  localparam int TU_CW   = TSF_W - TU_LOG2;

  logic             ctrl_wr;
  logic             clr_req;
  logic [PER_W-1:0] per_q;
  logic             en_q;
  logic             bcn_nz_q;
  logic             arm;
  logic [NUM_SLOTS-1:0] fire_w;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_req = ctrl_wr && wr_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q    <= '0;
      en_q     <= 1'b0;
      bcn_nz_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        per_q <= wr_data[PER_W-1:0];
        en_q  <= wr_data[EN_BIT];
      end
      if (wr_en && (wr_addr == ADDR_NEXT_BCN))
        bcn_nz_q <= |wr_data[TU_CW-1:0];
    end
  end

  assign arm = en_q && bcn_nz_q && (per_q != '0);

  bcn_tsf_counter #(.W(TSF_W)) u_tsf (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .clr_req (clr_req),
    .tsf     (tsf_us)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int SH = slot_is_fine(g) ? SUB_LOG2 : TU_LOG2;
    localparam int CW = TSF_W - SH;
    localparam int PS = slot_is_fine(g) ? 3 : 0;

    bcn_cmp_slot #(.CW(CW), .PER_W(PER_W), .PS(PS)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .field    (tsf_us[TSF_W-1:SH]),
      .load     (wr_en && (wr_addr == 3'(g))),
      .load_val (wr_data[CW-1:0]),
      .period   (per_q),
      .arm      (arm),
      .fire     (fire_w[g])
    );
  end

  assign ev_tbtt      = fire_w[0];
  assign ev_dma_alert = fire_w[1];
  assign ev_sw_alert  = fire_w[2];
  assign ev_win_end   = fire_w[3];

endmodule

// File: rtl/bcn_event_timer_chk.sv
module bcn_event_timer_chk #(
  parameter int TSF_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             clr_req,
  input logic             en_q,
  input logic [TSF_W-1:0] tsf_us,
  input logic             ev_tbtt,
  input logic             ev_dma_alert,
  input logic             ev_sw_alert,
  input logic             ev_win_end
);

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_req) |=> (tsf_us == $past(tsf_us) + TSF_W'(1)));

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr_req) |=> $stable(tsf_us));

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (tsf_us == '0));

  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !(ev_tbtt || ev_dma_alert || ev_sw_alert || ev_win_end));

  p_pulse_tbtt_r4: assert property (@(posedge clk) disable iff (rst)
    ev_tbtt |=> !ev_tbtt);

  p_pulse_dma_r5: assert property (@(posedge clk) disable iff (rst)
    ev_dma_alert |=> !ev_dma_alert);

endmodule

bind bcn_event_timer bcn_event_timer_chk #(.TSF_W(TSF_W)) u_chk (.*);

// File: tb/bcn_event_timer_test.sv
module bcn_event_timer_test;

  localparam int TSF_W   = 16;
  localparam int TU_LOG2 = 4;
  localparam int PER_W   = 8;
  localparam int WD_W    = 15;
  localparam int EN_BIT  = PER_W;
  localparam int CLR_BIT = PER_W + 1;
  localparam int TU_T    = 16;
  localparam int SUB_T   = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [WD_W-1:0]  wr_data = '0;
  logic [TSF_W-1:0] tsf_us;
  logic             ev_tbtt, ev_dma_alert, ev_sw_alert, ev_win_end;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  par = 1'b0;

  always #4 clk = ~clk;

  bcn_event_timer #(.TSF_W(TSF_W), .TU_LOG2(TU_LOG2), .PER_W(PER_W)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tsf_us(tsf_us), .ev_tbtt(ev_tbtt),
    .ev_dma_alert(ev_dma_alert), .ev_sw_alert(ev_sw_alert), .ev_win_end(ev_win_end)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 3'(addr);
    wr_data = WD_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wr_ctrl(input int per, input bit en, input bit clr);
    wr(4, per | (int'(en) << EN_BIT) | (int'(clr) << CLR_BIT));
    if (clr) par = ~par;
  endtask

  function automatic int any_ev();
    return int'(ev_tbtt) + int'(ev_dma_alert) + int'(ev_sw_alert) + int'(ev_win_end);
  endfunction

  task automatic count_events(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      n += any_ev();
    end
  endtask

  task automatic run_cfg(input int nb, input int per);
    int exp_t [4];
    logic [3:0] evs;
    wr_ctrl(0, 1'b0, 1'b0);
    wr(0, nb);
    wr(1, (nb - 1) * 8);
    wr(2, nb * 8 - 4);
    wr(3, nb + 1);
    wr_ctrl(per, 1'b1, 1'b1);
    check("R2 clear on control write", int'(tsf_us), 0);
    exp_t[0] = nb * TU_T + 1;
    exp_t[1] = (nb - 1) * 8 * SUB_T + 1;
    exp_t[2] = (nb * 8 - 4) * SUB_T + 1;
    exp_t[3] = (nb + 1) * TU_T + 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      evs = {ev_win_end, ev_sw_alert, ev_dma_alert, ev_tbtt};
      for (int ch = 0; ch < 4; ch++) begin
        if (evs[ch]) begin
          if (ch == 0 || ch == 3) check("R4/R6 TU event time", int'(tsf_us), exp_t[ch]);
          else check("R5/R6 eighth-TU event time", int'(tsf_us), exp_t[ch]);
          exp_t[ch] += per * TU_T;
        end
      end
    end
    for (int ch = 0; ch < 4; ch++)
      check("R6 no missed repetition", int'(exp_t[ch] > int'(tsf_us)), 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t0, n;
    repeat (3) @(negedge clk);
    check("R1 power-up counter", int'(tsf_us), 0);
    check("R3 events cleared in reset", any_ev(), 0);
    rst = 1'b0;

    // R1 tick gating
    t0 = int'(tsf_us);
    for (int i = 0; i < 30; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    check("R1 one step per tick", int'(tsf_us), t0 + 10);
    tick = 1'b1;
    t0 = int'(tsf_us);
    repeat (7) @(negedge clk);
    check("R1 continuous ticks", int'(tsf_us), t0 + 7);

    // sweep of next-beacon values and periods
    for (int nb = 1; nb <= 4; nb++)
      for (int per = 1; per <= 3; per++)
        run_cfg(nb, per);

    // R7 disabled and passed matches
    wr_ctrl(0, 1'b0, 1'b1);
    wr(0, 1); wr(1, 1); wr(2, 1); wr(3, 2);
    count_events(100, n);
    check("R7 no events while disabled", n, 0);
    wr_ctrl(2, 1'b1, 1'b0);
    count_events(120, n);
    check("R7 passed match does not fire", n, 0);

    // R8 zero next-beacon suppresses all
    wr_ctrl(0, 1'b0, 1'b0);
    wr(0, 0); wr(1, 4); wr(2, 4); wr(3, 3);
    wr_ctrl(2, 1'b1, 1'b1);
    count_events(150, n);
    check("R8 zero next beacon silences all", n, 0);
    wr(0, 2);
    wr_ctrl(2, 1'b1, 1'b1);
    n = 0;
    for (int i = 0; i < 100 && n == 0; i++) begin
      @(negedge clk);
      if (ev_tbtt) n = int'(tsf_us);
    end
    check("R8 nonzero write restores beacon", n, 2 * TU_T + 1);

    // R9 zero period
    wr_ctrl(0, 1'b0, 1'b0);
    wr(0, 1); wr(1, 0); wr(2, 0); wr(3, 2);
    wr_ctrl(0, 1'b1, 1'b1);
    count_events(100, n);
    check("R9 zero period silences all", n, 0);

    // R3 even parity: counter survives reset
    if (par) wr_ctrl(0, 1'b0, 1'b1);
    repeat (25) @(negedge clk);
    t0 = int'(tsf_us);
    check("R3 counter running before reset", int'(t0 >= 25), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R3 even flag keeps counter", int'(tsf_us), t0);
    wr_ctrl(1, 1'b1, 1'b0);
    count_events(60, n);
    check("R3 reset clears compare state", n, 0);

    // R3 odd parity: reset clears counter
    wr_ctrl(0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R3 odd flag clears counter", int'(tsf_us), 0);
    repeat (10) @(negedge clk);
    check("R1 counting after reset", int'(tsf_us), 10);
    wr_ctrl(0, 1'b0, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule